// File: doc/BRIEF.md
# Calibrated Seconds Timebase

This block turns a low-frequency oscillator rate (nominally 32,768 enabled cycles per second) into a one-cycle seconds pulse. The rate can be trimmed in fixed digital steps. The block runs on a system clock, and `osc_en` marks each oscillator cycle. A private second/minute position tracks where the block sits inside a repeating 64-minute correction window. In each of the first 2N minutes of that window, the opening second of the minute is made shorter or longer by a fixed number of cycles. N is the 5-bit magnitude in the control byte, and the sign bit picks the direction.

The same control byte drives a test pin. In test mode the pin shows a square wave taken from the uncorrected cycle count, which is 512 Hz at the default rate. Otherwise the pin mirrors a static level bit. The pin is open drain, so the block only reports whether it pulls the pin low. A stop input freezes every counter, and counting resumes from the frozen state when stop is released.

Control byte layout: bit 7 is the static pin level, bit 6 is test-wave enable, bit 5 is the sign (1 shortens, 0 lengthens), and bits 4:0 are the magnitude N.

Top module: `tbd_timebase`

## Requirements
- R1: A second that is not modified lasts exactly OSC_HZ advancing cycles. An advancing cycle is a clock edge with `osc_en`=1 and `stop`=0.
- R2: With magnitude N=0 no second is ever modified, whatever the sign bit is.
- R3: With the sign bit = 1 and N>0, each modified second lasts OSC_HZ-CORR_STEP advancing cycles (default 32,768-256).
- R4: With the sign bit = 0 and N>0, each modified second lasts OSC_HZ+CORR_STEP/2 advancing cycles (default 32,768+128).
- R5: Only second 0 of minutes 0 to 2N-1 of each 64-minute window is modified. Every other second of the window is nominal, and a full window holds 64×SEC_PER_MIN seconds.
- R6: `sec_tick` is high for exactly one clock cycle. It rises in the cycle after the edge that completes the second.
- R7: While `stop`=1, the cycle count, the position and the test wave hold, and `sec_tick` stays low.
- R8: With bit 6 = 1, `pin_pull_low` toggles every FT_HALF advancing cycles (32 by default, giving 512 Hz). The calibration value does not affect this rate.
- R9: With bit 6 = 0, `pin_pull_low` is the inverse of bit 7: the pin is pulled low when bit 7 is 0 and released when bit 7 is 1.
- R10: Clock edges with `osc_en`=0 do not advance any counter.
- R11: After reset the position is minute 0, second 0, cycle 0, and `sec_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| stop | input | 1 | Freeze all counting while high |
| ctrl_byte | input | 8 | Level bit, test enable, sign, magnitude |
| sec_tick | output | 1 | One-cycle pulse per completed second |
| pin_pull_low | output | 1 | 1 = pull the open-drain test pin low |

## Verification
The bench runs full 64-minute windows back to back and measures every second, for these control values:
- zero magnitude with each sign, which must leave every second nominal;
- +1, which modifies only two short seconds;
- −6, which adds twelve long seconds and has `osc_en` gaps;
- ±31, which modifies 62 seconds and sits at the edge of the window.

Each window tells apart a wrong step size, a wrong sign, a wrong minute limit and a wrong choice of modified second. Stop pulses placed mid-window must leave every measured length unchanged. The wave period is measured with the largest calibration applied, which shows whether the wave is taken from the uncorrected count.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
   typedef struct packed {
      logic       pin_level;
      logic       wave_en;
      logic       sign_fast;
      logic [4:0] mag;
   } ctrl_t;

   typedef enum logic [1:0] {
      CORR_NONE  = 2'd0,
      CORR_SHORT = 2'd1,
      CORR_LONG  = 2'd2
   } corr_e;
endpackage

// File: rtl/tbd_position.sv
module tbd_position
   import tbd_pkg::*;
#(
   parameter int SEC_PER_MIN = 60,
   localparam int SW = $clog2(SEC_PER_MIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wrap,
   input  ctrl_t         ctrl,
   output logic [SW-1:0] sec_cnt,
   output logic [5:0]    min_cnt,
   output corr_e         corr
);
   localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_cnt <= '0;
         min_cnt <= '0;
      end else if (wrap) begin
         if (sec_cnt == SEC_LAST) begin
            sec_cnt <= '0;
            min_cnt <= min_cnt + 6'd1;
         end else begin
            sec_cnt <= sec_cnt + SW'(1);
         end
      end
   end

   logic in_span;
   assign in_span = (ctrl.mag != 5'd0) && (min_cnt < {ctrl.mag, 1'b0}) && (sec_cnt == '0);

   always_comb begin
      corr = CORR_NONE;
      if (in_span) corr = ctrl.sign_fast ? CORR_SHORT : CORR_LONG;
   end
endmodule

// File: rtl/tbd_prescaler.sv
module tbd_prescaler
   import tbd_pkg::*;
#(
   parameter int OSC_HZ    = 32768,
   parameter int CORR_STEP = 256,
   localparam int CW = $clog2(OSC_HZ + CORR_STEP / 2 + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  corr_e         corr,
   output logic          wrap,
   output logic          tick,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LIM_NOM   = CW'(OSC_HZ - 1);
   localparam logic [CW-1:0] LIM_SHORT = CW'(OSC_HZ - 1 - CORR_STEP);
   localparam logic [CW-1:0] LIM_LONG  = CW'(OSC_HZ - 1 + CORR_STEP / 2);

   logic [CW-1:0] limit;
   always_comb begin
      unique case (corr)
         CORR_SHORT: limit = LIM_SHORT;
         CORR_LONG:  limit = LIM_LONG;
         default:    limit = LIM_NOM;
      endcase
   end

   assign wrap = adv && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= wrap;
         if (wrap)     cnt <= '0;
         else if (adv) cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/tbd_wavegen.sv
module tbd_wavegen #(
   parameter int FT_HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic phase
);
   generate
      if (FT_HALF == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   phase <= 1'b0;
            else if (adv) phase <= ~phase;
         end
      end else begin : g_count
         localparam int FW = $clog2(FT_HALF);
         localparam logic [FW-1:0] HLAST = FW'(FT_HALF - 1);
         logic [FW-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hcnt  <= '0;
               phase <= 1'b0;
            end else if (adv) begin
               if (hcnt == HLAST) begin
                  hcnt  <= '0;
                  phase <= ~phase;
               end else begin
                  hcnt <= hcnt + FW'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tbd_timebase.sv
module tbd_timebase
   import tbd_pkg::*;
#(
   parameter int OSC_HZ      = 32768,
   parameter int CORR_STEP   = 256,
   parameter int SEC_PER_MIN = 60,
   parameter int FT_HALF     = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en,
   input  logic       stop,
   input  logic [7:0] ctrl_byte,
   output logic       sec_tick,
   output logic       pin_pull_low
);
   localparam int CW = $clog2(OSC_HZ + CORR_STEP / 2 + 1);
   localparam int SW = $clog2(SEC_PER_MIN);

   generate
      if (CORR_STEP < 2 || (CORR_STEP % 2) != 0) begin : g_bad_step
         $error("CORR_STEP must be even and at least 2");
      end
      if (OSC_HZ <= CORR_STEP) begin : g_bad_rate
         $error("OSC_HZ must exceed CORR_STEP");
      end
      if (SEC_PER_MIN < 2) begin : g_bad_spm
         $error("SEC_PER_MIN must be at least 2");
      end
      if (FT_HALF < 1) begin : g_bad_half
         $error("FT_HALF must be at least 1");
      end
   endgenerate

   ctrl_t         ctrl;
   logic          adv, wrap, phase;
   corr_e         corr;
   logic [CW-1:0] cyc_cnt;
   logic [SW-1:0] sec_cnt;
   logic [5:0]    min_cnt;

   assign ctrl = ctrl_t'(ctrl_byte);
   assign adv  = osc_en && !stop;

   tbd_position #(.SEC_PER_MIN(SEC_PER_MIN)) pos_i (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .ctrl(ctrl),
      .sec_cnt(sec_cnt), .min_cnt(min_cnt), .corr(corr)
   );

   tbd_prescaler #(.OSC_HZ(OSC_HZ), .CORR_STEP(CORR_STEP)) pre_i (
      .clk(clk), .rst_n(rst_n), .adv(adv), .corr(corr),
      .wrap(wrap), .tick(sec_tick), .cnt(cyc_cnt)
   );

   tbd_wavegen #(.FT_HALF(FT_HALF)) wav_i (
      .clk(clk), .rst_n(rst_n), .adv(adv), .phase(phase)
   );

   assign pin_pull_low = ctrl.wave_en ? phase : ~ctrl.pin_level;
endmodule

// File: rtl/tbd_timebase_chk.sv
module tbd_timebase_chk #(
   parameter int CW      = 16,
   parameter int SW      = 6,
   parameter int SPM     = 60,
   parameter int LIM_MAX = 32895
) (
   input logic          clk,
   input logic          rst_n,
   input logic          osc_en,
   input logic          stop,
   input logic [7:0]    ctrl_byte,
   input logic          sec_tick,
   input logic          pin_pull_low,
   input logic [CW-1:0] cyc_cnt,
   input logic [SW-1:0] sec_cnt,
   input logic [5:0]    min_cnt
);
   a_r6_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   a_r7_stop_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !sec_tick);

   a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> ($stable(cyc_cnt) && $stable(sec_cnt) && $stable(min_cnt)));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> ($stable(cyc_cnt) && $stable(sec_cnt) && $stable(min_cnt)));

   a_r8_wave_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_byte[6] && stop) |=> (!ctrl_byte[6] || $stable(pin_pull_low)));

   a_r6_tick_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> (cyc_cnt == '0));

   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cyc_cnt) <= LIM_MAX);

   a_r5_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sec_cnt) < SPM);
endmodule

bind tbd_timebase tbd_timebase_chk #(
   .CW(CW), .SW(SW), .SPM(SEC_PER_MIN), .LIM_MAX(OSC_HZ - 1 + CORR_STEP / 2)
) chk_i (
   .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
   .ctrl_byte(ctrl_byte), .sec_tick(sec_tick), .pin_pull_low(pin_pull_low),
   .cyc_cnt(cyc_cnt), .sec_cnt(sec_cnt), .min_cnt(min_cnt)
);

// File: tb/tbd_timebase_tb_top.sv
module tbd_timebase_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int OSC_HZ     = 128;
   localparam int STEP       = 16;
   localparam int SPM        = 2;
   localparam int HALF       = 4;
   localparam int WATCHDOG   = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_en = 1'b0;
   logic stop = 1'b0;
   logic [7:0] ctrl_byte = 8'h00;
   logic sec_tick, pin_pull_low;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tbd_timebase #(.OSC_HZ(OSC_HZ), .CORR_STEP(STEP), .SEC_PER_MIN(SPM), .FT_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
      .ctrl_byte(ctrl_byte), .sec_tick(sec_tick), .pin_pull_low(pin_pull_low)
   );

   int n_vec = 0;
   int n_bad = 0;
   int exp_len[$];
   string exp_tag[$];
   int popped = 0;
   int run_len = 0;
   logic adv_seen = 1'b0;
   logic wave_watch = 1'b0;
   bit done = 1'b0;

   always @(posedge clk) adv_seen <= rst_n && osc_en && !stop;

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver side: push one 64-minute window of expected second lengths
   task automatic push_window(input logic [7:0] cb);
      int mag = int'(cb[4:0]);
      for (int m = 0; m < 64; m++) begin
         for (int s = 0; s < SPM; s++) begin
            if (s == 0 && mag != 0 && m < 2 * mag) begin
               exp_len.push_back(cb[5] ? OSC_HZ - STEP : OSC_HZ + STEP / 2);
               exp_tag.push_back(cb[5] ? "R3" : "R4");
            end else begin
               exp_len.push_back(OSC_HZ);
               exp_tag.push_back(mag == 0 ? "R2" : (s == 0 ? "R5" : "R1"));
            end
         end
      end
   endtask

   // monitor: measure every second and compare with the queue head
   always @(negedge clk) begin
      if (rst_n) begin
         if (adv_seen) run_len++;
         if (sec_tick) begin
            if (exp_len.size() == 0) begin
               check("R6 unexpected tick", 1, 0);
            end else begin
               check(exp_tag.pop_front(), run_len, exp_len.pop_front());
            end
            popped++;
            run_len = 0;
         end
      end
   end

   // wave monitor: period between pin changes, skipping the first two edges
   int w_cnt = 0;
   int w_edges = 0;
   logic w_last = 1'b0;
   always @(negedge clk) begin
      if (!wave_watch) begin
         w_edges = 0;
         w_cnt = 0;
         w_last = pin_pull_low;
      end else begin
         if (adv_seen) w_cnt++;
         if (pin_pull_low != w_last) begin
            if (w_edges >= 2) check("R8 wave half period", w_cnt, HALF);
            w_edges++;
            w_cnt = 0;
            w_last = pin_pull_low;
         end
      end
   end

   task automatic stop_burst(input int len);
      logic pin0;
      stop = 1'b1;
      @(negedge clk);
      pin0 = pin_pull_low;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         check("R7 tick low while stopped", int'(sec_tick), 0);
         check("R7 pin held while stopped", int'(pin_pull_low), int'(pin0));
      end
      #1 stop = 1'b0;
   endtask

   task automatic run_window(input logic [7:0] cb, input bit gaps, input bit stops);
      int target = popped + 64 * SPM;
      int cyc = 0;
      ctrl_byte = cb;
      push_window(cb);
      while (popped < target) begin
         @(negedge clk);
         #1;
         cyc++;
         osc_en = !(gaps && (cyc % 7 == 3));
         if (stops && (cyc % 4001 == 2000)) stop_burst(12);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R11 tick low in reset", int'(sec_tick), 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R11 tick low after reset", int'(sec_tick), 0);
      check("R9 pin pulled low with level bit 0", int'(pin_pull_low), 1);
      #1 osc_en = 1'b1;
      // R1 R2: zero magnitude, both signs
      run_window(8'h00, 1'b0, 1'b0);
      check("R9 pin pulled low with level bit 0", int'(pin_pull_low), 1);
      run_window(8'h20, 1'b0, 1'b0);
      // R3 R5: +1
      run_window(8'h21, 1'b0, 1'b0);
      // R4 R10 R9: -6 with enable gaps, level bit 1
      run_window(8'h86, 1'b1, 1'b0);
      check("R9 pin released with level bit 1", int'(pin_pull_low), 0);
      // R8 R7: +31 with test wave and stop bursts
      wave_watch = 1'b1;
      run_window(8'h7F, 1'b0, 1'b1);
      wave_watch = 1'b0;
      // R4 R5 R7: -31 with stop bursts
      run_window(8'h1F, 1'b1, 1'b1);
      check("R5 queue drained", exp_len.size(), 0);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
      if (!done) check("watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule